// File: doc/BRIEF.md
# Dual Masked Time Alarm Unit

This block watches a running clock/calendar kept in BCD and raises two independent alarms. Each alarm is a small set of byte registers: a compare value in bits 6..0 and a "don't care" bit in bit 7. The first alarm compares seconds, minutes, hours and a day/date byte; the second has no seconds byte and only fires on second 00, so its finest rate is once per minute. In each day/date byte, bit 6 picks whether bits 5..0 are compared with the day of week or with the date of the month.

The comparison is made only in the cycle where the one-second update strobe is high. A hit sets a sticky flag. Software clears a flag by writing a 0 to its bit, and writing a 1 has no effect. One output line is either an active-low interrupt, driven from flags whose enable is set, or a copy of the incoming 1 Hz square wave. A mode bit in the control register picks which.

Top module: `dual_alarm_unit`

## Requirements
- R1: After reset both flags are 0, the output is in interrupt mode with both enables 0, and `irq_sqw_n` is 1.
- R2: Register map: address 0..3 hold the first alarm's seconds, minutes, hours and day/date bytes; address 4..6 hold the second alarm's minutes, hours and day/date bytes. A byte with bit 7 set takes no part in the compare, so the first alarm with all four bit 7 set fires on every update.
- R3: When only the seconds byte of the first alarm is unmasked, a flag is set only on updates whose seconds equal bits 6..0 of that byte.
- R4: With all bytes unmasked, the day/date byte with bit 6 = 0 compares bits 5..0 with `t_date`, and with bit 6 = 1 compares them with `t_day`.
- R5: The hours compare covers bits 6..0 of the hours byte, 12-hour select and PM bits included, so an alarm written in the other hour format does not fire.
- R6: The second alarm fires only when `t_sec` is 8'h00. With all its bytes masked it fires once per minute, and unmasking minutes adds the minutes compare.
- R7: A flag can only become 1 in a cycle where `sec_tick` is 1. Matching time values without the strobe set nothing.
- R8: A write to address 8 clears flag 0 when data bit 0 is 0 and flag 1 when data bit 1 is 0. A 1 in either bit leaves that flag unchanged.
- R9: If a clear of a flag and a new hit for it fall in the same cycle, the flag ends up set.
- R10: Address 7 holds control: bit 2 is the mode (1 = interrupt), bit 1 enables flag 1, bit 0 enables flag 0. In interrupt mode `irq_sqw_n` is 0 exactly when some flag is set together with its enable.
- R11: With mode bit 0, `irq_sqw_n` follows `sq_1hz`, and hits still set the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe: the time fields have just advanced |
| t_sec | input | 8 | Current seconds, BCD |
| t_min | input | 8 | Current minutes, BCD |
| t_hour | input | 8 | Current hours byte (format bits included) |
| t_day | input | 8 | Current day of week |
| t_date | input | 8 | Current date of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| sq_1hz | input | 1 | 1 Hz square wave passed out in square-wave mode |
| alarm_flag | output | 2 | Sticky flags, bit 0 first alarm, bit 1 second alarm |
| irq_sqw_n | output | 1 | Active-low interrupt or square-wave output |

## Verification
The assertions take it for granted that `sec_tick` lasts a single cycle and that the time fields are already the new values in that cycle. They also assume the time bytes are legal BCD with bit 7 clear, since the compare treats a set bit 7 in a time byte as a mismatch. The stimulus applies each time value together with its strobe for exactly one cycle. It writes registers only from one-cycle strobes, and it keeps every time byte within its legal range. This includes hours bytes in the format the test intends, so a mismatch between formats comes only from the alarm side.

// File: rtl/dalm_pkg.sv
package dalm_pkg;
  localparam int NUM_AL   = 2;
  localparam int FIELDS   = 4;   // sec, min, hour, day/date
  localparam int BYTE_W   = 8;
  localparam int A2_BASE  = 4;
  localparam int CTRL_ADR = 7;
  localparam int FLAG_ADR = 8;

  // Register address of field f of alarm i (alarm 1 has no seconds field).
  function automatic int unsigned fld_addr(input int i, input int f);
    return (i == 0) ? f : (A2_BASE + f - 1);
  endfunction

  // Plain field: bit 7 masks, bits 6..0 must equal the whole time byte.
  function automatic logic field_hit(input logic [BYTE_W-1:0] al,
                                     input logic [BYTE_W-1:0] tv);
    return al[7] | ({1'b0, al[6:0]} == tv);
  endfunction

  // Day/date field: bit 6 selects day of week, bits 5..0 hold the value.
  function automatic logic dd_hit(input logic [BYTE_W-1:0] al,
                                  input logic [BYTE_W-1:0] day,
                                  input logic [BYTE_W-1:0] date);
    logic [BYTE_W-1:0] tgt;
    tgt = al[6] ? day : date;
    return al[7] | ({2'b00, al[5:0]} == tgt);
  endfunction
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import dalm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] al_sec,
  input  logic [BYTE_W-1:0] al_min,
  input  logic [BYTE_W-1:0] al_hour,
  input  logic [BYTE_W-1:0] al_dd,
  input  logic [BYTE_W-1:0] t_sec,
  input  logic [BYTE_W-1:0] t_min,
  input  logic [BYTE_W-1:0] t_hour,
  input  logic [BYTE_W-1:0] t_day,
  input  logic [BYTE_W-1:0] t_date,
  output logic              hit_o
);
  logic sec_ok, min_ok, hour_ok, dd_ok;

  always_comb begin
    sec_ok  = field_hit(al_sec, t_sec);
    min_ok  = field_hit(al_min, t_min);
    hour_ok = field_hit(al_hour, t_hour);
    dd_ok   = dd_hit(al_dd, t_day, t_date);
    hit_o   = sec_ok & min_ok & hour_ok & dd_ok;
  end

  // R2: every field masked means a hit whatever the time says
  p_all_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (al_sec[7] && al_min[7] && al_hour[7] && al_dd[7]) |-> hit_o);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // a hit beats a clear
    else if (clr_i) flag_o <= 1'b0;
  end

  p_rise_needs_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_i));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit
  import dalm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [BYTE_W-1:0] t_sec,
  input  logic [BYTE_W-1:0] t_min,
  input  logic [BYTE_W-1:0] t_hour,
  input  logic [BYTE_W-1:0] t_day,
  input  logic [BYTE_W-1:0] t_date,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              sq_1hz,
  output logic [NUM_AL-1:0] alarm_flag,
  output logic              irq_sqw_n
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADR);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADR);

  logic [BYTE_W-1:0] al_q [NUM_AL][FIELDS];
  logic              mode_irq_q;
  logic [NUM_AL-1:0] ie_q;
  logic [NUM_AL-1:0] hit, set_ev, clr_ev;
  logic              flag_wr, irq_req;

  // Alarm byte registers; the second alarm's seconds byte is a fixed 00.
  for (genvar i = 0; i < NUM_AL; i++) begin : g_al
    for (genvar f = 0; f < FIELDS; f++) begin : g_fld
      if (i == 1 && f == 0) begin : g_fix
        assign al_q[i][f] = '0;
      end else begin : g_reg
        localparam logic [ADDR_W-1:0] FA = ADDR_W'(fld_addr(i, f));
        always_ff @(posedge clk) begin
          if (!rst_n)                     al_q[i][f] <= '0;
          else if (wr_en && wr_addr == FA) al_q[i][f] <= wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_irq_q <= 1'b1;
      ie_q       <= '0;
    end else if (wr_en && wr_addr == CTRL_A) begin
      mode_irq_q <= wr_data[2];
      ie_q       <= wr_data[1:0];
    end
  end

  assign flag_wr = wr_en && (wr_addr == FLAG_A);

  for (genvar i = 0; i < NUM_AL; i++) begin : g_unit
    alarm_match u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .al_sec (al_q[i][0]),
      .al_min (al_q[i][1]),
      .al_hour(al_q[i][2]),
      .al_dd  (al_q[i][3]),
      .t_sec  (t_sec),
      .t_min  (t_min),
      .t_hour (t_hour),
      .t_day  (t_day),
      .t_date (t_date),
      .hit_o  (hit[i])
    );
    assign set_ev[i] = sec_tick & hit[i];
    assign clr_ev[i] = flag_wr & ~wr_data[i];
    alarm_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_ev[i]),
      .clr_i (clr_ev[i]),
      .flag_o(alarm_flag[i])
    );
  end

  assign irq_req   = |(alarm_flag & ie_q);
  assign irq_sqw_n = mode_irq_q ? ~irq_req : sq_1hz;

  // R7: no new flag appears after a cycle without the update strobe
  p_no_set_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> ((alarm_flag & ~$past(alarm_flag)) == '0));
  // R6: the second alarm never sets on a nonzero seconds value
  p_a2_sec_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && t_sec != '0 && !alarm_flag[1]) |=> !alarm_flag[1]);
  // R10: with no enables in interrupt mode the line stays released
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_irq_q && ie_q == '0) |-> irq_sqw_n);
endmodule

// File: tb/dual_alarm_unit_tb_top.sv
module dual_alarm_unit_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] t_sec = '0, t_min = '0, t_hour = '0, t_day = 8'h01, t_date = 8'h01;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sq_1hz = 1'b0;
  logic [1:0] alarm_flag;
  logic       irq_sqw_n;

  always #(CLK_P/2) clk = ~clk;

  dual_alarm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_day(t_day), .t_date(t_date),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sq_1hz(sq_1hz),
    .alarm_flag(alarm_flag), .irq_sqw_n(irq_sqw_n)
  );

  // staged time values, copied to the DUT at the next driving edge
  logic [7:0] n_s = '0, n_m = '0, n_h = '0, n_dy = 8'h01, n_dt = 8'h01;
  logic       n_sq = 1'b0;

  // reference model state
  logic [7:0] m_al [2][4];
  logic [2:0] m_ctrl;
  logic [1:0] m_fl;

  typedef struct packed { logic [1:0] fl; logic irq; } exp_t;
  exp_t  exp_q [$];
  string tag_q [$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  function automatic bit bhit(int i);
    bit ok = 1;
    logic [7:0] tgt;
    if (i == 0) begin
      if (!m_al[0][0][7] && (m_al[0][0][6:0] != n_s[6:0] || n_s[7])) ok = 0;
    end else if (n_s != 8'h00) ok = 0;
    if (!m_al[i][1][7] && (m_al[i][1][6:0] != n_m[6:0] || n_m[7])) ok = 0;
    if (!m_al[i][2][7] && (m_al[i][2][6:0] != n_h[6:0] || n_h[7])) ok = 0;
    if (!m_al[i][3][7]) begin
      tgt = m_al[i][3][6] ? n_dy : n_dt;
      if (m_al[i][3][5:0] != tgt[5:0] || tgt[7:6] != 2'b00) ok = 0;
    end
    return ok;
  endfunction

  task automatic step(bit tk, bit we, logic [3:0] a, logic [7:0] d, string tag);
    bit [1:0] h;
    exp_t e;
    @(negedge clk);
    sec_tick = tk; wr_en = we; wr_addr = a; wr_data = d;
    t_sec = n_s; t_min = n_m; t_hour = n_h; t_day = n_dy; t_date = n_dt;
    sq_1hz = n_sq;
    h = {bhit(1), bhit(0)};
    for (int i = 0; i < 2; i++) begin
      if (tk && h[i]) m_fl[i] = 1'b1;
      else if (we && a == 4'd8 && !d[i]) m_fl[i] = 1'b0;
    end
    if (we) begin
      if (a <= 4'd3) m_al[0][a] = d;
      else if (a <= 4'd6) m_al[1][a - 4'd3] = d;
      else if (a == 4'd7) m_ctrl = d[2:0];
    end
    e.fl  = m_fl;
    e.irq = m_ctrl[2] ? !(|(m_fl & m_ctrl[1:0])) : n_sq;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d, string tag);
    step(0, 1, a, d, tag);
  endtask

  task automatic tick(string tag);
    step(1, 0, 4'd0, 8'h00, tag);
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s,
                          logic [7:0] dy, logic [7:0] dt);
    n_h = h; n_m = m; n_s = s; n_dy = dy; n_dt = dt;
  endtask

  // monitor: pops the expected item right after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (alarm_flag !== e.fl || irq_sqw_n !== e.irq) begin
          errors++;
          $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b",
                   t, alarm_flag, irq_sqw_n, e.fl, e.irq);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++)
      for (int f = 0; f < 4; f++) m_al[i][f] = 8'h00;
    m_ctrl = 3'b100;
    m_fl   = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    step(0, 0, 4'd0, 8'h00, "R1 reset state");
    wr(4'd7, 8'h07, "R10 enable both, interrupt mode");

    // R2 every second
    wr(4'd0, 8'h80, "R2 setup"); wr(4'd1, 8'h80, "R2 setup");
    wr(4'd2, 8'h80, "R2 setup"); wr(4'd3, 8'h80, "R2 setup");
    set_time(8'h12, 8'h34, 8'h56, 8'h03, 8'h15);
    tick("R2 fully masked fires, R10 irq low");

    // R8 clear semantics
    wr(4'd8, 8'h03, "R8 write ones keeps flag");
    wr(4'd8, 8'hFE, "R8 write zero clears flag");
    step(0, 0, 4'd0, 8'h00, "R7 no strobe no flag");
    step(1, 1, 4'd8, 8'h00, "R9 hit beats clear");
    wr(4'd8, 8'h00, "R8 clear all");

    // R3 seconds only
    wr(4'd0, 8'h30, "R3 setup");
    set_time(8'h12, 8'h34, 8'h29, 8'h03, 8'h15);
    tick("R3 seconds differ");
    set_time(8'h12, 8'h34, 8'h30, 8'h03, 8'h15);
    tick("R3 seconds equal");
    wr(4'd8, 8'h00, "R8 clear all");

    // R4 date / day select
    wr(4'd0, 8'h00, "R4 setup"); wr(4'd1, 8'h15, "R4 setup");
    wr(4'd2, 8'h08, "R4 setup"); wr(4'd3, 8'h21, "R4 setup");
    set_time(8'h08, 8'h15, 8'h00, 8'h05, 8'h21);
    tick("R4 date match");
    wr(4'd8, 8'h00, "R8 clear all");
    wr(4'd3, 8'h45, "R4 select day");
    set_time(8'h08, 8'h15, 8'h00, 8'h02, 8'h05);
    tick("R4 day select ignores date");
    set_time(8'h08, 8'h15, 8'h00, 8'h05, 8'h12);
    tick("R4 day match");
    wr(4'd8, 8'h00, "R8 clear all");

    // R5 hour format
    wr(4'd2, 8'h48, "R5 setup 12h alarm");
    tick("R5 24h time no match");
    set_time(8'h48, 8'h15, 8'h00, 8'h05, 8'h12);
    tick("R5 12h time match");
    wr(4'd8, 8'h00, "R8 clear all");

    // R6 second alarm
    wr(4'd4, 8'h80, "R6 setup"); wr(4'd5, 8'h80, "R6 setup"); wr(4'd6, 8'h80, "R6 setup");
    set_time(8'h10, 8'h40, 8'h01, 8'h05, 8'h12);
    tick("R6 second 01 no fire");
    set_time(8'h10, 8'h40, 8'h00, 8'h05, 8'h12);
    tick("R6 second 00 fires");
    wr(4'd8, 8'h00, "R8 clear all");
    wr(4'd4, 8'h40, "R6 minutes setup");
    set_time(8'h10, 8'h41, 8'h00, 8'h05, 8'h12);
    tick("R6 minutes differ");
    set_time(8'h10, 8'h40, 8'h00, 8'h05, 8'h12);
    tick("R6 minutes equal");

    // R10 enables
    wr(4'd7, 8'h05, "R10 enable only first, second set");
    wr(4'd7, 8'h06, "R10 enable second");

    // R11 square-wave mode
    n_sq = 1'b1;
    wr(4'd7, 8'h02, "R11 square mode high");
    n_sq = 1'b0;
    step(0, 0, 4'd0, 8'h00, "R11 square mode low");
    wr(4'd0, 8'h80, "R11 setup"); wr(4'd1, 8'h80, "R11 setup");
    wr(4'd2, 8'h80, "R11 setup"); wr(4'd3, 8'h80, "R11 setup");
    n_sq = 1'b1;
    tick("R11 flag still sets in square mode");

    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule